// File: doc/BRIEF.md
# Banked Scratchpad Conflict Scheduler

This block sits in front of a banked on-chip shared memory. A vector requester hands it a group of lane addresses in one cycle, each a dword address, together with a lane-enable mask, a load/store flag and per-lane store data. The block splits the address into a bank index and a row. It finds the lanes that would collide in the same bank and replays the group over as many passes as are needed to serve every enabled lane. Lanes that name the same dword in a pass share that bank's single access.

Each pass steers the granted lanes' rows and store data through an address crossbar to the banks, one access port per bank. A read crossbar then routes each bank's output back to every lane that targeted it. When the last pass finishes, the block raises a one-cycle done strobe. The strobe carries the per-lane load data, the enable mask of the group and the number of passes the group took. While a group still has passes left, the block refuses new work. The default build has 32 banks of 64 rows. Setting the row parameter to 512 gives the full 64 KB configuration.

Top module: `sp_conflict_top`

## Requirements
- R1: While reset is held and right after it, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A lane's bank is dword address bits [4:0] (log2 of the bank count). Its row is the remaining upper bits. Two addresses that differ only in the upper bits collide in one bank.
- R3: A group whose enabled lanes all target different banks is served in one pass. `rsp_valid` rises exactly one cycle after the accepting edge, with `rsp_passes` = 1.
- R4: Enabled lanes that carry the same dword address are served in the same pass and add no pass.
- R5: In each pass, the lowest-numbered pending lane claims its bank. Other lanes on that bank that carry a different address wait. The pass count equals the largest number of distinct enabled addresses that fall in any single bank.
- R6: `req_ready` is 0 from the accepting edge until the final pass of the group has completed, so no second group is taken meanwhile.
- R7: For a load, each enabled lane returns the word last stored at its address. Disabled lanes return zero.
- R8: For a store in which several enabled lanes carry the same address, the word written is the data of the lowest-numbered of those lanes.
- R9: A group that needs N passes (N ≥ 1) produces exactly one `rsp_valid` pulse, N cycles after the accepting edge, with `rsp_mask` equal to the accepted mask.
- R10: A group with an all-zero mask reports 0 passes one cycle after acceptance, and leaves the memory unchanged.
- R11: A store response returns zero on every lane of `rsp_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A lane group is offered |
| req_ready | output | 1 | Group accepted on this edge when high together with req_valid |
| req_store | input | 1 | 1 = store group, 0 = load group |
| req_mask | input | LANES (16) | Lane enable, bit i for lane i |
| req_addr | input | LANES*AW (176) | Dword address per lane, lane i in bits [i*AW +: AW] |
| req_wdata | input | LANES*DW (512) | Store data per lane, lane i in bits [i*DW +: DW] |
| rsp_valid | output | 1 | One-cycle done strobe for the group |
| rsp_mask | output | LANES (16) | Lane enable of the completed group |
| rsp_rdata | output | LANES*DW (512) | Load data per lane, zero for disabled lanes and stores |
| rsp_passes | output | PW (5) | Number of passes the group used |

## Verification
The scoreboard predicts the pass count N of each group from its addresses before driving it. It then expects the done strobe exactly max(N,1) cycles after the accepting edge. That cycle number is queued with the expected data, mask and pass count, and the monitor compares the observed cycle against it. Inputs change and outputs are read on the falling edge, so every registered result has settled before it is sampled. For groups of more than one pass, the falling edge after acceptance also checks that ready has dropped.

// File: rtl/sp_sched_pkg.sv
package sp_sched_pkg;
    typedef enum logic {
        SP_LOAD  = 1'b0,
        SP_STORE = 1'b1
    } sp_op_e;
endpackage

// File: rtl/sp_conflict_detect.sv
// Per-pass grant: a pending lane is granted when its address equals the
// address of the lowest-numbered pending lane that maps to the same bank.
module sp_conflict_detect #(
    parameter int LANES = 16,
    parameter int AW    = 11,
    parameter int BW    = 5
) (
    input  logic [LANES-1:0]         pend,
    input  logic [LANES-1:0][AW-1:0] addr,
    output logic [LANES-1:0]         grant
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic          hit;
        logic [AW-1:0] owner;
        logic          lane_grant;

        always_comb begin
            hit   = 1'b0;
            owner = addr[i];
            for (int j = 0; j < i; j++) begin
                if (!hit && pend[j] && (addr[j][BW-1:0] == addr[i][BW-1:0])) begin
                    hit   = 1'b1;
                    owner = addr[j];
                end
            end
            lane_grant = pend[i] && (owner == addr[i]);
        end

        assign grant[i] = lane_grant;
    end
endmodule

// File: rtl/sp_bank_array.sv
// Banks with one port each; the address crossbar picks the owning lane per
// bank, the read crossbar returns each bank's word to every lane on it.
module sp_bank_array #(
    parameter int LANES = 16,
    parameter int BANKS = 32,
    parameter int ROWS  = 64,
    parameter int DW    = 32,
    parameter int BW    = 5,
    parameter int AW    = 11
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [LANES-1:0]         grant,
    input  logic [LANES-1:0][AW-1:0] addr,
    input  logic [LANES-1:0][DW-1:0] wdata,
    output logic [LANES-1:0][DW-1:0] lane_rd
);
    localparam int RW = AW - BW;

    logic [BANKS-1:0][DW-1:0] bank_rd;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        logic [DW-1:0] mem [ROWS];
        logic          hit;
        logic [RW-1:0] row;
        logic [DW-1:0] wd;

        always_comb begin
            hit = 1'b0;
            row = '0;
            wd  = '0;
            for (int j = 0; j < LANES; j++) begin
                if (!hit && grant[j] && (addr[j][BW-1:0] == BW'(b))) begin
                    hit = 1'b1;
                    row = addr[j][AW-1:BW];
                    wd  = wdata[j];
                end
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && hit) begin
                mem[row] <= wd;
            end
        end

        assign bank_rd[b] = mem[row];
    end

    for (genvar i = 0; i < LANES; i++) begin : g_rxbar
        assign lane_rd[i] = bank_rd[addr[i][BW-1:0]];
    end
endmodule

// File: rtl/sp_conflict_top.sv
module sp_conflict_top #(
    parameter int LANES = 16,
    parameter int BANKS = 32,
    parameter int ROWS  = 64,
    parameter int DW    = 32,
    localparam int BW   = $clog2(BANKS),
    localparam int RW   = $clog2(ROWS),
    localparam int AW   = BW + RW,
    localparam int PW   = $clog2(LANES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_store,
    input  logic [LANES-1:0]    req_mask,
    input  logic [LANES*AW-1:0] req_addr,
    input  logic [LANES*DW-1:0] req_wdata,
    output logic                rsp_valid,
    output logic [LANES-1:0]    rsp_mask,
    output logic [LANES*DW-1:0] rsp_rdata,
    output logic [PW-1:0]       rsp_passes
);
    import sp_sched_pkg::*;

    typedef struct packed {
        logic                     busy;
        logic                     done;
        sp_op_e                   op;
        logic [LANES-1:0]         mask;
        logic [LANES-1:0]         pend;
        logic [LANES-1:0][AW-1:0] addr;
        logic [LANES-1:0][DW-1:0] wdata;
        logic [LANES-1:0][DW-1:0] rdata;
        logic [PW-1:0]            passes;
    } state_t;

    state_t q, d;

    logic [LANES-1:0]         det_pend;
    logic [LANES-1:0]         grant;
    logic [LANES-1:0]         left;
    logic [LANES-1:0][DW-1:0] lane_rd;
    logic                     wr_en;

    assign det_pend = q.busy ? q.pend : '0;
    assign wr_en    = q.busy && (q.op == SP_STORE);
    assign left     = q.pend & ~grant;

    sp_conflict_detect #(.LANES(LANES), .AW(AW), .BW(BW)) u_detect (
        .pend  (det_pend),
        .addr  (q.addr),
        .grant (grant)
    );

    sp_bank_array #(
        .LANES(LANES), .BANKS(BANKS), .ROWS(ROWS),
        .DW(DW), .BW(BW), .AW(AW)
    ) u_banks (
        .clk     (clk),
        .wr_en   (wr_en),
        .grant   (grant),
        .addr    (q.addr),
        .wdata   (q.wdata),
        .lane_rd (lane_rd)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (req_valid) begin
                d.busy   = 1'b1;
                d.op     = req_store ? SP_STORE : SP_LOAD;
                d.mask   = req_mask;
                d.pend   = req_mask;
                d.addr   = req_addr;
                d.wdata  = req_wdata;
                d.rdata  = '0;
                d.passes = '0;
            end
        end else begin
            for (int i = 0; i < LANES; i++) begin
                if (grant[i] && (q.op == SP_LOAD)) begin
                    d.rdata[i] = lane_rd[i];
                end
            end
            d.pend = left;
            if (grant != '0) begin
                d.passes = q.passes + PW'(1);
            end
            if (left == '0) begin
                d.busy = 1'b0;
                d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = !q.busy;
    assign rsp_valid  = q.done;
    assign rsp_mask   = q.mask;
    assign rsp_rdata  = q.rdata;
    assign rsp_passes = q.passes;
endmodule

// File: rtl/sp_conflict_chk.sv
module sp_conflict_chk #(
    parameter int LANES = 16,
    parameter int DW    = 32,
    parameter int PW    = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                rsp_valid,
    input logic [LANES-1:0]    rsp_mask,
    input logic [LANES*DW-1:0] rsp_rdata,
    input logic [PW-1:0]       rsp_passes
);
    logic off_lanes_zero;

    always_comb begin
        off_lanes_zero = 1'b1;
        for (int i = 0; i < LANES; i++) begin
            if (!rsp_mask[i] && (rsp_rdata[i*DW +: DW] != '0)) begin
                off_lanes_zero = 1'b0;
            end
        end
    end

    AST_READY_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready); // R6

    AST_ACCEPT_LEADS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_valid || !req_ready)); // R9

    AST_PASSES_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (32'(rsp_passes) <= $countones(rsp_mask))); // R5

    AST_EMPTY_NO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_mask == '0)) |-> (rsp_passes == '0)); // R10

    AST_WORK_HAS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_mask != '0)) |-> (rsp_passes != '0)); // R5

    AST_OFF_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> off_lanes_zero); // R7
endmodule

bind sp_conflict_top sp_conflict_chk #(.LANES(LANES), .DW(DW), .PW(PW)) u_chk (.*);

// File: tb/tb_sp_conflict_top.sv
`timescale 1ns/1ps
module tb_sp_conflict_top;
    localparam int L     = 16;
    localparam int B     = 32;
    localparam int R     = 64;
    localparam int DW    = 32;
    localparam int BW    = 5;
    localparam int AW    = 11;
    localparam int PW    = 5;
    localparam int WORDS = B * R;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic                   req_valid = 1'b0;
    logic                   req_ready;
    logic                   req_store = 1'b0;
    logic [L-1:0]           req_mask = '0;
    logic [L-1:0][AW-1:0]   req_addr = '0;
    logic [L-1:0][DW-1:0]   req_wdata = '0;
    logic                   rsp_valid;
    logic [L-1:0]           rsp_mask;
    logic [L-1:0][DW-1:0]   rsp_rdata;
    logic [PW-1:0]          rsp_passes;

    sp_conflict_top #(.LANES(L), .BANKS(B), .ROWS(R), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_store(req_store),
        .req_mask(req_mask), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_mask(rsp_mask),
        .rsp_rdata(rsp_rdata), .rsp_passes(rsp_passes)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_bad = 0;
    logic [DW-1:0] ref_mem [WORDS];

    int                   q_cyc  [$];
    int                   q_pass [$];
    logic [L-1:0]         q_mask [$];
    logic [L-1:0][DW-1:0] q_data [$];
    string                q_tag  [$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Driver: predicts the result, queues it, then offers the group.
    task automatic send(input bit st, input logic [L-1:0] m,
                        input logic [L-1:0][AW-1:0] a,
                        input logic [L-1:0][DW-1:0] wd, input string tag);
        int cnt [B];
        int np;
        logic [L-1:0][DW-1:0] ed;
        np = 0;
        for (int b = 0; b < B; b++) cnt[b] = 0;
        for (int i = 0; i < L; i++) begin
            bit first;
            first = m[i];
            for (int j = 0; j < i; j++)
                if (m[j] && a[j] == a[i]) first = 0;
            if (first) begin
                cnt[a[i][BW-1:0]]++;
                if (cnt[a[i][BW-1:0]] > np) np = cnt[a[i][BW-1:0]];
            end
        end
        for (int i = 0; i < L; i++)
            ed[i] = (!st && m[i]) ? ref_mem[a[i]] : '0;
        if (st)
            for (int i = L - 1; i >= 0; i--)
                if (m[i]) ref_mem[a[i]] = wd[i];
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        q_cyc.push_back(cyc + 1 + ((np == 0) ? 1 : np));
        q_pass.push_back(np);
        q_mask.push_back(m);
        q_data.push_back(ed);
        q_tag.push_back(tag);
        req_valid = 1'b1;
        req_store = st;
        req_mask  = m;
        req_addr  = a;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (np > 1)
            check(req_ready == 1'b0, "R6", "ready during replay", 512'(req_ready), 512'(0));
    endtask

    // Monitor: pops the oldest expectation on each done strobe.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (q_cyc.size() == 0) begin
                check(1'b0, "R9", "unexpected response", 512'(1), 512'(0));
            end else begin
                int ec, ep;
                logic [L-1:0] em;
                logic [L-1:0][DW-1:0] edat;
                string tg;
                ec = q_cyc.pop_front();
                ep = q_pass.pop_front();
                em = q_mask.pop_front();
                edat = q_data.pop_front();
                tg = q_tag.pop_front();
                check(cyc == ec, {tg, " R9"}, "response cycle", 512'(cyc), 512'(ec));
                check(32'(rsp_passes) == ep, {tg, " R5"}, "pass count", 512'(rsp_passes), 512'(ep));
                check(rsp_mask == em, {tg, " R9"}, "mask echo", 512'(rsp_mask), 512'(em));
                check(rsp_rdata == edat, {tg, " R7"}, "lane data", 512'(rsp_rdata), 512'(edat));
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R9", "watchdog expired", 512'(cyc), 512'(0));
        finish_run();
    end

    initial begin
        logic [L-1:0][AW-1:0] a;
        logic [L-1:0][DW-1:0] wd;
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "in reset",
              512'({req_ready, rsp_valid}), 512'(2'b10));
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1", "after reset",
              512'({req_ready, rsp_valid}), 512'(2'b10));

        // R3: fill with conflict-free store groups, stores return zero (R11)
        for (int base = 0; base < WORDS; base += L) begin
            for (int i = 0; i < L; i++) begin
                a[i]  = AW'(base + i);
                wd[i] = $urandom;
            end
            send(1'b1, '1, a, wd, "R3 R11");
        end

        // R3/R7: conflict-free load
        for (int i = 0; i < L; i++) a[i] = AW'(i + 16);
        send(1'b0, '1, a, wd, "R3");

        // R4: every lane on one dword
        for (int i = 0; i < L; i++) a[i] = AW'(100);
        send(1'b0, '1, a, wd, "R4");

        // R5: one bank, sixteen rows
        for (int i = 0; i < L; i++) a[i] = AW'(i * 32 + 7);
        send(1'b0, '1, a, wd, "R5");

        // R4/R5: pairs sharing a dword, eight rows on bank 3
        for (int i = 0; i < L; i++) a[i] = AW'((i / 2) * 32 + 3);
        send(1'b0, '1, a, wd, "R4 R5");

        // R2: addresses 5 and 37 share bank 5
        a = '0;
        a[0] = AW'(5); a[1] = AW'(37);
        wd[0] = 32'hA5A5_0005; wd[1] = 32'h5A5A_0025;
        send(1'b1, 16'h0003, a, wd, "R2");
        send(1'b0, 16'h0003, a, wd, "R2");

        // R8: duplicate-address store keeps lane 0
        for (int i = 0; i < L; i++) begin
            a[i]  = AW'(200);
            wd[i] = 32'hC0DE_0000 + i;
        end
        send(1'b1, '1, a, wd, "R8");
        send(1'b0, 16'h0001, a, wd, "R8");

        // R7: partial mask load
        for (int i = 0; i < L; i++) a[i] = AW'(300 + i * 5);
        send(1'b0, 16'h00F0, a, wd, "R7");

        // R10: empty store then a load of the same words
        for (int i = 0; i < L; i++) begin
            a[i]  = AW'(400 + i);
            wd[i] = 32'hDEAD_0000 + i;
        end
        send(1'b1, '0, a, wd, "R10");
        send(1'b0, '0, a, wd, "R10");
        send(1'b0, '1, a, wd, "R10");

        // Random groups with dense conflicts
        for (int n = 0; n < 80; n++) begin
            logic [L-1:0] m;
            bit st;
            st = $urandom_range(0, 1);
            m  = L'($urandom);
            for (int i = 0; i < L; i++) begin
                a[i]  = (n % 2 == 0) ? AW'($urandom_range(0, 127)) : AW'($urandom);
                wd[i] = $urandom;
            end
            send(st, m, a, wd, "R5 R7 R9");
        end

        repeat (40) @(negedge clk);
        check(q_cyc.size() == 0, "R9", "responses outstanding", 512'(q_cyc.size()), 512'(0));
        finish_run();
    end
endmodule